// File: doc/BRIEF.md
# RGB-to-Gray Averaging Stream Converter

This block sits on a byte-wide streaming path (valid, ready, last) in front of an image buffer writer. Colour pixels reach it as three consecutive bytes, red first, then green, then blue. It collects each group of three, adds the three bytes and divides the total by three, rounding down. The result leaves on an output stream of the same kind as a single gray byte.

The divide is exact for every sum that three bytes can produce. An end-of-packet marker on the blue byte is passed on to the gray byte. If the marker arrives on the red or green byte, the pixel is incomplete: it is dropped without producing any output, and the next byte starts a fresh pixel.

The output is held in one register. While that register holds a result the consumer has not yet taken, the input is not ready. The block keeps no frame storage. With the default widths, a 256x256 frame of 196608 input bytes becomes 65536 output bytes.

Top module: `rgb_gray_stream`

## Requirements
- R1: Accepted input bytes are grouped in threes, in red, green, blue order. Each complete group produces exactly one output byte.
- R2: The output byte equals floor((red + green + blue) / 3). This is exact for all byte values from 0 to 255, that is, for every sum from 0 to 765.
- R3: When all three bytes of a pixel are 127 or less, the output byte is 127 or less, so its bit 7 is 0.
- R4: The output last flag is 1 when the input last flag was 1 on the third byte of that pixel, and 0 otherwise.
- R5: An input byte accepted with last = 1 as the first or second byte of a pixel discards the partial pixel and produces no output. The next accepted byte is the red byte of a new pixel.
- R6: Once out_valid is 1, it stays 1 with out_data and out_last unchanged until a cycle in which out_ready is 1.
- R7: in_ready is 0 exactly while an output is waiting to be taken, and 1 otherwise.
- R8: After reset, out_valid is 0, in_ready is 1, and the next accepted byte is the red byte of a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Input colour byte |
| in_valid | input | 1 | Input byte is valid |
| in_last | input | 1 | Input byte ends a packet |
| in_ready | output | 1 | Block can accept an input byte |
| out_data | output | 8 | Gray output byte |
| out_valid | output | 1 | Output byte is valid |
| out_last | output | 1 | Output byte ends a packet |
| out_ready | input | 1 | Consumer takes the output byte |

## Verification
Fixed pixels with sums of 0, 1, 2, 3, 380, 381, 382 and 765 exercise every remainder of the divide, as well as its upper range. These cases separate an exact divide from an approximate one. A ramp and random pixels limited to 127 exercise the 7-bit range, and random full-range bytes exercise wide sums. Packets cut after one byte and after two bytes show whether a partial pixel is dropped or wrongly merged into the next one. Random gaps on the input and stalls on the output test whether a result is held stable and whether input is blocked while a result is pending.

// File: rtl/gray_pkg.sv
package gray_pkg;
  parameter int DATA_W = 8;
  localparam int SUM_W = DATA_W + 2;
  // reciprocal of three as 683 / 2^11: exact for sums below 2046
  localparam int DIV_SH = 11;
  localparam logic [DIV_SH-1:0] DIV_MUL = 11'd683;

  function automatic logic [SUM_W-1:0] div3(input logic [SUM_W-1:0] s);
    logic [SUM_W+DIV_SH-1:0] p;
    p = {{DIV_SH{1'b0}}, s} * {{SUM_W{1'b0}}, DIV_MUL};
    return p[SUM_W+DIV_SH-1:DIV_SH];
  endfunction
endpackage

// File: rtl/triplet_gather.sv
module triplet_gather
  import gray_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [DATA_W-1:0] byte_in,
  input  logic             last_in,
  output logic             pix_done,
  output logic             pix_drop,
  output logic [SUM_W-1:0] pix_sum,
  output logic             pix_last
);
  logic [1:0]       phase;
  logic [SUM_W-1:0] acc;

  assign pix_sum  = acc + {2'b00, byte_in};
  assign pix_done = take && (phase == 2'd2);
  assign pix_drop = take && last_in && (phase != 2'd2);
  assign pix_last = last_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 2'd0;
      acc   <= '0;
    end else if (take) begin
      if (pix_done || last_in) begin
        phase <= 2'd0;
        acc   <= '0;
      end else begin
        phase <= phase + 2'd1;
        acc   <= pix_sum;
      end
    end
  end

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !last_in && phase != 2'd2) |=> (phase == $past(phase) + 2'd1));
  assert_drop_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_drop |=> (phase == 2'd0 && acc == '0));
endmodule

// File: rtl/gray_out_stage.sv
module gray_out_stage
  import gray_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_last  <= load_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
  assert_load_shows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
endmodule

// File: rtl/rgb_gray_stream.sv
module rgb_gray_stream
  import gray_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last,
  input  logic              out_ready
);
  localparam int CHK_W = SUM_W + 2;

  logic             take;
  logic             pix_done;
  logic             pix_drop;
  logic             pix_last;
  logic [SUM_W-1:0] pix_sum;
  logic [SUM_W-1:0] gray_full;
  logic [CHK_W-1:0] q_times3;
  logic [CHK_W-1:0] sum_ext;

  assign in_ready  = !out_valid;
  assign take      = in_valid && in_ready;
  assign gray_full = div3(pix_sum);
  assign q_times3  = {2'b00, gray_full} * CHK_W'(3);
  assign sum_ext   = {2'b00, pix_sum};

  triplet_gather gather_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .byte_in  (in_data),
    .last_in  (in_last),
    .pix_done (pix_done),
    .pix_drop (pix_drop),
    .pix_sum  (pix_sum),
    .pix_last (pix_last)
  );

  gray_out_stage out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pix_done),
    .load_data (gray_full[DATA_W-1:0]),
    .load_last (pix_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  assert_div_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_done |-> (q_times3 <= sum_ext && sum_ext < q_times3 + CHK_W'(3)));
  assert_fits_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_done |-> (gray_full[SUM_W-1:DATA_W] == '0));
  assert_drop_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_drop |=> !out_valid);
  assert_last_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_done |=> (out_last == $past(in_last)));
endmodule

// File: tb/rgb_gray_stream_tb_top.sv
module rgb_gray_stream_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_last;
  logic       out_ready = 1'b0;

  always #2.5 clk = ~clk;

  rgb_gray_stream dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
  );

  int vectors = 0;
  int miscmp = 0;
  int byte_q[$];
  bit last_q[$];
  int exp_pix = 0;
  int got_pix = 0;

  // reference model state
  int  m_phase = 0, m_sum = 0, m_data = 0;
  bit  m_ov = 0, m_last = 0, m_small = 1, m_cur_small = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_pix(input int r, input int g, input int b, input bit l);
    byte_q.push_back(r); last_q.push_back(1'b0);
    byte_q.push_back(g); last_q.push_back(1'b0);
    byte_q.push_back(b); last_q.push_back(l);
    exp_pix++;
  endtask

  task automatic push_cut(input int n);
    for (int i = 0; i < n; i++) begin
      byte_q.push_back(40 + i * 7);
      last_q.push_back(i == n - 1);
    end
  endtask

  initial begin
    int cyc;
    bit fire_in, fire_out;
    // fixed remainder and range cases
    push_pix(0, 0, 0, 0);
    push_pix(1, 0, 0, 0);
    push_pix(1, 1, 0, 0);
    push_pix(1, 1, 1, 1);
    push_pix(127, 127, 126, 0);
    push_pix(127, 127, 127, 0);
    push_pix(127, 127, 128, 1);
    push_pix(255, 255, 255, 1);
    push_cut(1);
    push_pix(10, 20, 31, 0);
    push_cut(2);
    push_pix(90, 3, 7, 1);
    for (int i = 0; i < 126; i += 3) push_pix(i, i + 1, i + 2, (i % 12) == 9);
    for (int i = 0; i < 300; i++)
      push_pix($urandom_range(127), $urandom_range(127), $urandom_range(127),
               $urandom_range(9) == 0);
    push_cut(1);
    push_cut(2);
    for (int i = 0; i < 200; i++)
      push_pix($urandom_range(255), $urandom_range(255), $urandom_range(255),
               $urandom_range(7) == 0);

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8 in_ready after reset", in_ready, 1);

    cyc = 0;
    while (byte_q.size() > 0 || m_ov) begin
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", cyc, 100000);
        break;
      end
      // compare against model state left by the last edge
      chk(out_valid == m_ov, "R1 out_valid", out_valid, m_ov);
      if (m_ov && out_valid) begin
        chk(out_data == m_data, "R2 out_data", out_data, m_data);
        chk(out_last == m_last, "R4 out_last", out_last, m_last);
        if (m_small) chk(out_data[7] == 1'b0, "R3 7-bit result", out_data, m_data);
      end
      chk(in_ready == !m_ov, "R7 in_ready", in_ready, !m_ov);
      // drive next cycle
      if (cyc < 1500) begin
        in_valid = byte_q.size() > 0;
        out_ready = 1'b1;
      end else begin
        in_valid = byte_q.size() > 0 && $urandom_range(3) != 0;
        out_ready = $urandom_range(2) != 0;
      end
      in_data = (byte_q.size() > 0) ? 8'(byte_q[0]) : 8'h00;
      in_last = (byte_q.size() > 0) ? last_q[0] : 1'b0;
      #1;
      fire_in = in_valid && in_ready;
      fire_out = out_valid && out_ready;
      // model the coming edge; R6 follows from keeping state when not fired
      if (fire_out) begin
        m_ov = 0;
        got_pix++;
      end
      if (fire_in) begin
        void'(byte_q.pop_front());
        void'(last_q.pop_front());
        if (m_phase == 0) m_cur_small = 1;
        if (in_data > 127) m_cur_small = 0;
        if (m_phase == 2) begin
          m_ov = 1;
          m_data = (m_sum + in_data) / 3;
          m_last = in_last;
          m_small = m_cur_small;
          m_phase = 0;
          m_sum = 0;
        end else if (in_last) begin
          m_phase = 0;
          m_sum = 0;
        end else begin
          m_phase++;
          m_sum += in_data;
        end
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(got_pix == exp_pix, "R1 R5 pixel count", got_pix, exp_pix);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule